// File: doc/BRIEF.md
# Three-dimensional DMA address walker

This block produces the address stream for one DMA channel. A transfer is described in three dimensions: an array is a run of contiguous bytes, a frame is a group of arrays, and a block is a group of frames. For every sync trigger it presents source/destination start addresses with a byte length, one array at a time, on a ready/valid output. In one-array mode a trigger yields a single array. In whole-frame mode a trigger yields every array of the current frame.

The channel's active configuration is copied from a small parameter RAM, either on request or automatically at the end of a block. At the end of a block a link field selects the next entry. The null link value instead leaves the channel exhausted. Each trigger's portion ends with a one-cycle pulse that marks it as either an intermediate or the final completion. The block generates addresses only. Moving bytes and bus transactions are handled elsewhere.

Top module: `dma3d_agen`

## Requirements
- R1: After reset no item is offered, `busy` and all pulses are low, and the active counts are zero, so a trigger only produces a one-cycle `trig_err` pulse in the next cycle.
- R2: In one-array mode (mode bit 0) a trigger produces exactly one item: the current source and destination array starts, with `item_len` equal to the A count.
- R3: Within a frame, each array start follows the previous one by its own sign-extended 16-bit B stride, kept separately for source and destination. Addresses wrap modulo 2^32.
- R4: In one-array mode the array after the last array of a frame starts at the last array's start plus the C stride. That frame ends the C count down by one, and the new frame's array count is taken from the B-count reload field.
- R5: In whole-frame mode (mode bit 1) a trigger produces B count items. The next frame's first array starts at the previous frame's first array plus the C stride.
- R6: The cycle after the handshake of a portion's last item shows a single-cycle pulse. That pulse is `done_last` when the C count reaches zero, and `done_mid` otherwise. The two pulses are never high together.
- R7: At final completion with a link other than 0xFFFF, the active set is replaced by the RAM entry whose index is link bits [7:5]. No item appears until the next trigger.
- R8: At final completion with link 0xFFFF, the counts are cleared. Every later trigger is ignored and answered by `trig_err`.
- R9: A trigger that arrives while items are still being offered is ignored and raises `trig_err` in the next cycle.
- R10: While `item_valid` is high and `item_ready` is low, the item's fields stay unchanged.
- R11: A trigger presented in the cycle that shows a done pulse is accepted, and its first item is offered in the next cycle.
- R12: A RAM entry is one word packed from the most significant bit down as: mode bit, source (32), destination (32), A, B, C counts, B-count reload (16 each), source B stride, destination B stride, source C stride, destination C stride (16 each, signed), link (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Write strobe for a parameter RAM entry |
| ram_idx | input | 3 | Entry written |
| ram_wdata | input | 209 | Entry contents, packed as in R12 |
| ld_req | input | 1 | Copy entry `ld_idx` into the active set (honoured when idle) |
| ld_idx | input | 3 | Entry to copy |
| trig | input | 1 | Sync trigger |
| item_valid | output | 1 | An item is offered |
| item_ready | input | 1 | Consumer accepts the item |
| item_src | output | 32 | Source array start |
| item_dst | output | 32 | Destination array start |
| item_len | output | 16 | Array length in bytes |
| done_mid | output | 1 | Intermediate completion pulse |
| done_last | output | 1 | Final completion pulse |
| trig_err | output | 1 | Ignored trigger pulse |
| busy | output | 1 | A portion is in progress |

## Verification
Two functions can fall in the same cycle. The first is the end of one portion, shown by its done pulse. The second is the acceptance of the next trigger. The bench provokes this by raising `trig` in exactly the cycle whose outputs show the pulse. A behavioural model, which precomputes each portion's address list into a queue, expects that trigger to be taken and the first item of the next portion to be offered one cycle later. A trigger raised during a stalled portion provides the contrasting case, where the model expects a `trig_err` pulse and no change to the remaining items.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  parameter int ADDR_W = 32;
  parameter int CNT_W  = 16;
  parameter int STR_W  = 16;
  parameter int LINK_W = 16;
  localparam logic [LINK_W-1:0] LINK_NULL = '1;
  localparam int LINK_SHIFT = 5;

  typedef enum logic {S_IDLE, S_EMIT} walk_st_e;

  typedef struct packed {
    logic              frame_mode;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  acnt;
    logic [CNT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  ccnt;
    logic [CNT_W-1:0]  brld;
    logic [STR_W-1:0]  src_bstr;
    logic [STR_W-1:0]  dst_bstr;
    logic [STR_W-1:0]  src_cstr;
    logic [STR_W-1:0]  dst_cstr;
    logic [LINK_W-1:0] link;
  } pset_t;

  localparam int PSET_W = $bits(pset_t);

  function automatic logic [ADDR_W-1:0] sext(input logic [STR_W-1:0] v);
    return {{(ADDR_W-STR_W){v[STR_W-1]}}, v};
  endfunction
endpackage

// File: rtl/dma3d_rst_sync.sv
module dma3d_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dma3d_pram.sv
module dma3d_pram
  import dma3d_pkg::*;
#(
  parameter int NSETS = 8,
  localparam int IW = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  pset_t         wdata,
  input  logic [IW-1:0] ridx,
  output pset_t         rdata
);
  pset_t mem [NSETS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/dma3d_walker.sv
module dma3d_walker
  import dma3d_pkg::*;
#(
  parameter int NSETS = 8,
  localparam int IW = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              ld_req,
  input  logic [IW-1:0]     ld_idx,
  output logic [IW-1:0]     rd_idx,
  input  pset_t             rd_set,
  input  logic              item_ready,
  output logic              item_valid,
  output logic [ADDR_W-1:0] item_src,
  output logic [ADDR_W-1:0] item_dst,
  output logic [CNT_W-1:0]  item_len,
  output logic              done_mid,
  output logic              done_last,
  output logic              trig_err,
  output logic              busy
);
  walk_st_e          st_q, st_d;
  pset_t             cfg_q, cfg_d;
  logic [ADDR_W-1:0] cur_src_q, cur_src_d, cur_dst_q, cur_dst_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d, kleft_q, kleft_d;
  logic              mid_q, mid_d, last_q, last_d, err_q, err_d;
  logic              fire, port_end, blk_end, do_load, do_zero, dp_en;

  assign fire     = (st_q == S_EMIT) && item_ready;
  assign port_end = cfg_q.frame_mode ? (kleft_q == CNT_W'(1)) : 1'b1;
  assign blk_end  = port_end && (cfg_q.ccnt == CNT_W'(1)) &&
                    (cfg_q.frame_mode || (bcnt_q == CNT_W'(1)));
  assign rd_idx   = (st_q == S_EMIT) ? cfg_q.link[LINK_SHIFT +: IW] : ld_idx;
  assign dp_en    = (st_q == S_EMIT) ? fire : (trig | ld_req);

  always_comb begin
    st_d = st_q; cfg_d = cfg_q;
    cur_src_d = cur_src_q; cur_dst_d = cur_dst_q;
    bcnt_d = bcnt_q; kleft_d = kleft_q;
    mid_d = 1'b0; last_d = 1'b0; err_d = 1'b0;
    do_load = 1'b0; do_zero = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (trig) begin
          if (cfg_q.ccnt == '0) err_d = 1'b1;
          else begin
            st_d    = S_EMIT;
            kleft_d = cfg_q.frame_mode ? cfg_q.bcnt : CNT_W'(1);
          end
        end else if (ld_req) begin
          do_load = 1'b1;
        end
      end
      default: begin
        err_d = trig;
        if (fire) begin
          if (cfg_q.frame_mode) begin
            if (!port_end) begin
              cur_src_d = cur_src_q + sext(cfg_q.src_bstr);
              cur_dst_d = cur_dst_q + sext(cfg_q.dst_bstr);
              kleft_d   = kleft_q - CNT_W'(1);
            end else begin
              cfg_d.src  = cfg_q.src + sext(cfg_q.src_cstr);
              cfg_d.dst  = cfg_q.dst + sext(cfg_q.dst_cstr);
              cur_src_d  = cfg_q.src + sext(cfg_q.src_cstr);
              cur_dst_d  = cfg_q.dst + sext(cfg_q.dst_cstr);
              cfg_d.ccnt = cfg_q.ccnt - CNT_W'(1);
            end
          end else if (bcnt_q == CNT_W'(1)) begin
            cur_src_d  = cur_src_q + sext(cfg_q.src_cstr);
            cur_dst_d  = cur_dst_q + sext(cfg_q.dst_cstr);
            bcnt_d     = cfg_q.brld;
            cfg_d.ccnt = cfg_q.ccnt - CNT_W'(1);
          end else begin
            cur_src_d = cur_src_q + sext(cfg_q.src_bstr);
            cur_dst_d = cur_dst_q + sext(cfg_q.dst_bstr);
            bcnt_d    = bcnt_q - CNT_W'(1);
          end
          if (port_end) begin
            st_d = S_IDLE;
            if (blk_end) begin
              last_d = 1'b1;
              if (cfg_q.link != LINK_NULL) do_load = 1'b1;
              else                         do_zero = 1'b1;
            end else begin
              mid_d = 1'b1;
            end
          end
        end
      end
    endcase
    if (do_load) begin
      cfg_d     = rd_set;
      cur_src_d = rd_set.src;
      cur_dst_d = rd_set.dst;
      bcnt_d    = rd_set.bcnt;
    end
    if (do_zero) begin
      cfg_d.acnt = '0; cfg_d.bcnt = '0; cfg_d.ccnt = '0;
      bcnt_d     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; mid_q <= 1'b0; last_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; mid_q <= mid_d; last_q <= last_d; err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; cur_src_q <= '0; cur_dst_q <= '0; bcnt_q <= '0; kleft_q <= '0;
    end else if (dp_en) begin
      cfg_q <= cfg_d; cur_src_q <= cur_src_d; cur_dst_q <= cur_dst_d;
      bcnt_q <= bcnt_d; kleft_q <= kleft_d;
    end
  end

  assign item_valid = (st_q == S_EMIT);
  assign busy       = (st_q == S_EMIT);
  assign item_src   = cur_src_q;
  assign item_dst   = cur_dst_q;
  assign item_len   = cfg_q.acnt;
  assign done_mid   = mid_q;
  assign done_last  = last_q;
  assign trig_err   = err_q;

  // R10
  item_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && !item_ready |=> item_valid && $stable(item_src) &&
                                  $stable(item_dst) && $stable(item_len));
  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_mid && done_last));
  // R6
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_mid || done_last) |-> $past(item_valid && item_ready));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_last |=> !done_last);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_err |-> $past(trig));
  // R8
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_err && !$past(busy) |-> !busy);
endmodule

// File: rtl/dma3d_agen.sv
module dma3d_agen
  import dma3d_pkg::*;
#(
  parameter int NUM_SETS = 8,
  localparam int SET_IW = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_we,
  input  logic [SET_IW-1:0] ram_idx,
  input  logic [PSET_W-1:0] ram_wdata,
  input  logic              ld_req,
  input  logic [SET_IW-1:0] ld_idx,
  input  logic              trig,
  output logic              item_valid,
  input  logic              item_ready,
  output logic [ADDR_W-1:0] item_src,
  output logic [ADDR_W-1:0] item_dst,
  output logic [CNT_W-1:0]  item_len,
  output logic              done_mid,
  output logic              done_last,
  output logic              trig_err,
  output logic              busy
);
  logic              rst_n_s;
  logic [SET_IW-1:0] rd_idx;
  pset_t             rd_set;

  dma3d_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dma3d_pram #(.NSETS(NUM_SETS)) u_pram (
    .clk(clk), .we(ram_we), .widx(ram_idx), .wdata(pset_t'(ram_wdata)),
    .ridx(rd_idx), .rdata(rd_set)
  );

  dma3d_walker #(.NSETS(NUM_SETS)) u_walk (
    .clk(clk), .rst_n(rst_n_s), .trig(trig), .ld_req(ld_req), .ld_idx(ld_idx),
    .rd_idx(rd_idx), .rd_set(rd_set), .item_ready(item_ready),
    .item_valid(item_valid), .item_src(item_src), .item_dst(item_dst),
    .item_len(item_len), .done_mid(done_mid), .done_last(done_last),
    .trig_err(trig_err), .busy(busy)
  );
endmodule

// File: tb/dma3d_agen_tb_top.sv
`timescale 1ns/1ps
module dma3d_agen_tb_top;
  import dma3d_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, ram_we, ld_req, trig, item_ready;
  logic [2:0]        ram_idx, ld_idx;
  logic [PSET_W-1:0] ram_wdata;
  logic              item_valid, done_mid, done_last, trig_err, busy;
  logic [31:0]       item_src, item_dst;
  logic [15:0]       item_len;

  dma3d_agen dut_i (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_idx(ram_idx),
    .ram_wdata(ram_wdata), .ld_req(ld_req), .ld_idx(ld_idx), .trig(trig),
    .item_valid(item_valid), .item_ready(item_ready), .item_src(item_src),
    .item_dst(item_dst), .item_len(item_len), .done_mid(done_mid),
    .done_last(done_last), .trig_err(trig_err), .busy(busy)
  );

  typedef struct { logic [31:0] s; logic [31:0] d; } item_t;
  item_t q[$];
  pset_t ram_m [8];

  int n_chk = 0, n_fail = 0, tick = 0;
  bit stall = 0, finished = 0;
  string cur_req = "R1";

  // model state
  bit m_ab; logic [31:0] m_src, m_dst, m_fs, m_fd;
  int m_a, m_b, m_c, m_rld, m_sb, m_db, m_sc, m_dc, m_link;
  // post-portion state
  logic [31:0] p_src, p_dst, p_fs, p_fd; int p_b, p_c;
  bit e_mid, e_last, e_err;

  task automatic m_load(pset_t p);
    m_ab = p.frame_mode; m_src = p.src; m_dst = p.dst; m_fs = p.src; m_fd = p.dst;
    m_a = p.acnt; m_b = p.bcnt; m_c = p.ccnt; m_rld = p.brld;
    m_sb = $signed(p.src_bstr); m_db = $signed(p.dst_bstr);
    m_sc = $signed(p.src_cstr); m_dc = $signed(p.dst_cstr); m_link = p.link;
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    item_t it;
    item_ready = stall ? ((tick % 3) != 2) : 1'b1;
    tick++;
    e_mid = 0; e_last = 0; e_err = 0;
    if (q.size() > 0) begin
      if (trig) e_err = 1;
      if (item_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          m_src = p_src; m_dst = p_dst; m_fs = p_fs; m_fd = p_fd; m_b = p_b; m_c = p_c;
          if (m_c == 0) begin
            e_last = 1;
            if (m_link != 'hFFFF) m_load(ram_m[m_link >> 5]);
            else begin m_a = 0; m_b = 0; m_c = 0; end
          end else e_mid = 1;
        end
      end
    end else if (trig) begin
      if (m_c == 0) e_err = 1;
      else if (m_ab) begin
        for (int k = 0; k < m_b; k++) begin
          it.s = m_fs + 32'(k * m_sb); it.d = m_fd + 32'(k * m_db); q.push_back(it);
        end
        p_fs = m_fs + 32'(m_sc); p_fd = m_fd + 32'(m_dc);
        p_src = p_fs; p_dst = p_fd; p_b = m_b; p_c = m_c - 1;
      end else begin
        it.s = m_src; it.d = m_dst; q.push_back(it);
        p_fs = m_fs; p_fd = m_fd;
        if (m_b == 1) begin
          p_src = m_src + 32'(m_sc); p_dst = m_dst + 32'(m_dc); p_b = m_rld; p_c = m_c - 1;
        end else begin
          p_src = m_src + 32'(m_sb); p_dst = m_dst + 32'(m_db); p_b = m_b - 1; p_c = m_c;
        end
      end
    end else if (ld_req) m_load(ram_m[ld_idx]);
    if (ram_we) ram_m[ram_idx] = pset_t'(ram_wdata);
    @(posedge clk); #2;
    chk("busy", 32'(busy), 32'(q.size() > 0));
    chk("valid", 32'(item_valid), 32'(q.size() > 0));
    if (q.size() > 0) begin
      chk("src", item_src, q[0].s);
      chk("dst", item_dst, q[0].d);
      chk("len", 32'(item_len), 32'(m_a));
    end
    chk("done_mid", 32'(done_mid), 32'(e_mid));
    chk("done_last", 32'(done_last), 32'(e_last));
    chk("trig_err", 32'(trig_err), 32'(e_err));
  endtask

  task automatic fire_trig(); trig = 1; cyc(); trig = 0; endtask
  task automatic drain();
    for (int n = 0; n < 400 && q.size() > 0; n++) cyc();
  endtask
  task automatic wr(int idx, pset_t p);
    ram_we = 1; ram_idx = 3'(idx); ram_wdata = p; cyc(); ram_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL %s watchdog act=hung exp=finished", cur_req);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pset_t s0, s1;
    rst_n = 0; ram_we = 0; ld_req = 0; trig = 0; item_ready = 1;
    ram_idx = 0; ld_idx = 0; ram_wdata = '0;
    m_ab = 0; m_src = 0; m_dst = 0; m_fs = 0; m_fd = 0;
    m_a = 0; m_b = 0; m_c = 0; m_rld = 0; m_sb = 0; m_db = 0; m_sc = 0; m_dc = 0; m_link = 0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    // R1: reset state and a trigger with zero counts
    cur_req = "R1";
    repeat (3) cyc();
    fire_trig();
    cyc();

    // R12: field packing of entries
    cur_req = "R12";
    s0 = '{frame_mode: 1'b0, src: 32'h1000, dst: 32'h8000, acnt: 16'd2, bcnt: 16'd3,
           ccnt: 16'd2, brld: 16'd2, src_bstr: 16'd4, dst_bstr: -16'sd8,
           src_cstr: 16'd100, dst_cstr: -16'sd200, link: 16'd32};
    s1 = '{frame_mode: 1'b1, src: 32'h2000, dst: 32'h3000, acnt: 16'd4, bcnt: 16'd3,
           ccnt: 16'd2, brld: 16'd1, src_bstr: 16'd4, dst_bstr: 16'h8000,
           src_cstr: -16'sd50, dst_cstr: 16'd7, link: 16'hFFFF};
    wr(0, s0); wr(1, s1);
    ld_req = 1; ld_idx = 0; cyc(); ld_req = 0;
    cyc();

    cur_req = "R2"; fire_trig(); drain(); cyc();
    cur_req = "R3"; fire_trig(); drain(); cyc();
    cur_req = "R4"; fire_trig(); drain(); fire_trig(); drain(); cyc();
    cur_req = "R6"; fire_trig(); drain();
    // R7: reload from entry 1 without starting
    cur_req = "R7";
    repeat (4) cyc();
    chk("no item after reload", 32'(item_valid), 32'd0);

    cur_req = "R5"; fire_trig(); drain(); cyc();
    cur_req = "R10"; stall = 1; fire_trig(); drain(); stall = 0; cyc();
    cur_req = "R8"; fire_trig(); cyc(); fire_trig(); cyc();

    cur_req = "R9";
    ld_req = 1; ld_idx = 1; cyc(); ld_req = 0;
    stall = 1; fire_trig(); cyc(); fire_trig(); drain(); stall = 0;
    cur_req = "R11";
    fire_trig();
    chk("accepted in done cycle", 32'(busy), 32'd1);
    drain(); cyc();
    cur_req = "R8"; fire_trig(); cyc();

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule